// File: doc/BRIEF.md
# Folded Polyphase Matched and Derivative Filter Engine

This block is the arithmetic core of a timing recovery loop for a receiver that runs at two samples per symbol. One sample history holds the most recent complex input samples. It feeds two polyphase filters at once: a matched filter and a derivative matched filter. Each filter bank has 32 arms of 24 real coefficients, taken from a 768-tap prototype. On each request, the engine computes one output of each filter for the arm chosen by the loop. Both filters are time-shared over the taps, so each filter path does one multiply-accumulate per tap per cycle.

A caller writes complex samples into the history while the engine is idle. It then pulses `fire` with an arm index. After a fixed 24-cycle pass, the engine returns three results together with a one-cycle `done` pulse:
- the rounded complex matched filter output;
- the rounded real part of the derivative output;
- the timing error, which is the product of the real matched output and the derivative output.

These results are held until the next accepted request. Both coefficient banks are computed at elaboration from parameters.

The control state machine has three states:
- `ST_IDLE`: waiting for a request. On an accepted `fire` it moves to `ST_RUN`.
- `ST_RUN`: one tap per cycle. After the last tap it moves to `ST_DONE`.
- `ST_DONE`: a single cycle in which `done` is high. It then always returns to `ST_IDLE`.

Top module: `trf_pmf_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, all result outputs are 0, and every sample history entry is zero.
- R2: When `in_valid` is high while idle, the sample (`in_i`, `in_q`) enters history position 0 (newest). Every older entry moves from position t to position t+1, and the entry at position 23 is discarded.
- R3: A sample presented with `in_valid` while `busy` is high is discarded and leaves the history unchanged.
- R4: When `fire` is sampled high while idle, the engine becomes busy. `busy` is high from the following cycle for exactly 25 cycles. `done` is high only in the last of these cycles, which is 24 cycles after `busy` rises and exactly one cycle after the final accumulate.
- R5: A `fire` pulse while `busy` is high is ignored. It does not restart the pass, change the arm in use or extend `busy`.
- R6: The arm p and tap t pair prototype index k = p + 32·t with history position t, for p in 0..31 and t in 0..23. The coefficient storage address is p·24 + t. The matched outputs are `mf_i` = round(Σ h[k]·xi[t]) and `mf_q` = round(Σ h[k]·xq[t]), both signed.
- R7: The derivative output `dmf_out` = round(Σ d[k]·xi[t]) uses the in-phase samples only.
- R8: The coefficients are the low 12 bits, read as two's complement, of the following values: h[k] = (1237·k + 91) mod 4096 and d[k] = (2903·k + 517) mod 4096.
- R9: Each sum is accumulated at full precision in 29 bits. It is then rounded to 16 bits as (sum + 4096) >>> 13, where >>> is an arithmetic shift.
- R10: `ted_err` is the signed 32-bit product `mf_i`·`dmf_out`.
- R11: The results stay unchanged from the `done` cycle until the next accepted `fire`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write strobe for the sample history |
| in_i | input | 12 | In-phase sample, signed |
| in_q | input | 12 | Quadrature sample, signed |
| fire | input | 1 | Start a pass |
| fire_arm | input | 5 | Arm index for the pass |
| busy | output | 1 | A pass is in progress, including the done cycle |
| done | output | 1 | One-cycle pulse: results are valid |
| mf_i | output | 16 | Matched filter output, in-phase |
| mf_q | output | 16 | Matched filter output, quadrature |
| dmf_out | output | 16 | Derivative filter output, real part |
| ted_err | output | 32 | Timing error product |

## Verification
The assertions assume that `fire` and `in_valid` are held for whole cycles and are sampled only at rising edges. They also assume that `fire_arm` matters only when a request is accepted. The stimulus changes every input on the falling edge, and it deliberately raises `fire` and `in_valid` inside a pass to exercise R3 and R5. The sample values, including the most negative in-phase sample, and the arm indices both stay within their declared widths. As a result, the accumulators never reach the overflow that the width choice excludes.

// File: rtl/trf_pkg.sv
package trf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } trf_state_e;

    // Elaboration-time coefficient generator: low cw bits of (mul*k + add),
    // read back as a two's complement value.
    function automatic int trf_coef(int k, int mul, int add, int cw);
        int raw;
        raw = (k * mul + add) % (1 << cw);
        if (raw >= (1 << (cw - 1)))
            raw = raw - (1 << cw);
        return raw;
    endfunction

endpackage

// File: rtl/trf_coef_rom.sv
module trf_coef_rom #(
    parameter int NUM_ARMS = 32,
    parameter int TAPS     = 24,
    parameter int COEF_W   = 12,
    parameter int MUL      = 1237,
    parameter int ADD      = 91,
    localparam int DEPTH   = NUM_ARMS * TAPS,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic        [ADDR_W-1:0] addr,
    output logic signed [COEF_W-1:0] coef
);
    import trf_pkg::*;

    logic signed [COEF_W-1:0] rom [DEPTH];

    // Address arm*TAPS + tap holds prototype tap arm + NUM_ARMS*tap.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int ARM   = g / TAPS;
        localparam int TAP   = g % TAPS;
        localparam int PROTO = ARM + NUM_ARMS * TAP;
        assign rom[g] = COEF_W'(trf_coef(PROTO, MUL, ADD, COEF_W));
    end

    assign coef = rom[addr];

endmodule

// File: rtl/trf_regressor.sv
module trf_regressor #(
    parameter int DEPTH  = 24,
    parameter int DATA_W = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic signed [DATA_W-1:0] din_i,
    input  logic signed [DATA_W-1:0] din_q,
    input  logic        [IDX_W-1:0]  rd_idx,
    output logic signed [DATA_W-1:0] rd_i,
    output logic signed [DATA_W-1:0] rd_q
);

    logic signed [DATA_W-1:0] hist_i [DEPTH];
    logic signed [DATA_W-1:0] hist_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist_i[g] <= '0;
                hist_q[g] <= '0;
            end else if (shift_en) begin
                if (g == 0) begin
                    hist_i[g] <= din_i;
                    hist_q[g] <= din_q;
                end else begin
                    hist_i[g] <= hist_i[g-1];
                    hist_q[g] <= hist_q[g-1];
                end
            end
        end
    end

    assign rd_i = hist_i[rd_idx];
    assign rd_q = hist_q[rd_idx];

    // R3: without a write strobe from the controller the history is frozen
    p_hold_without_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(hist_i[0]) && $stable(hist_q[0])
                       && $stable(hist_i[DEPTH-1]) && $stable(hist_q[DEPTH-1])));

endmodule

// File: rtl/trf_mac_lane.sv
module trf_mac_lane #(
    parameter int DATA_W  = 12,
    parameter int COEF_W  = 12,
    parameter int ACC_W   = 29,
    parameter int OUT_W   = 16,
    localparam int PROD_W = DATA_W + COEF_W,
    localparam int SHIFT  = ACC_W - OUT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] sample,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [OUT_W-1:0]  result
);

    logic signed [ACC_W-1:0]  acc_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  biased;

    assign prod     = sample * coef;
    assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc_q <= '0;
        else if (en)
            acc_q <= acc_q + prod_ext;
    end

    // Round half up, then drop SHIFT fraction bits (arithmetic).
    assign biased = acc_q + ACC_W'(1 << (SHIFT - 1));
    assign result = biased[ACC_W-1:SHIFT];

endmodule

// File: rtl/trf_pmf_engine.sv
module trf_pmf_engine #(
    parameter int NUM_ARMS = 32,
    parameter int TAPS     = 24,
    parameter int DATA_W   = 12,
    parameter int COEF_W   = 12,
    parameter int OUT_W    = 16,
    parameter int MF_MUL   = 1237,
    parameter int MF_ADD   = 91,
    parameter int DMF_MUL  = 2903,
    parameter int DMF_ADD  = 517,
    localparam int ARM_W   = $clog2(NUM_ARMS),
    localparam int TAP_W   = $clog2(TAPS),
    localparam int ADDR_W  = $clog2(NUM_ARMS * TAPS),
    localparam int ACC_W   = DATA_W + COEF_W + $clog2(TAPS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [DATA_W-1:0]   in_i,
    input  logic signed [DATA_W-1:0]   in_q,
    input  logic                       fire,
    input  logic        [ARM_W-1:0]    fire_arm,
    output logic                       busy,
    output logic                       done,
    output logic signed [OUT_W-1:0]    mf_i,
    output logic signed [OUT_W-1:0]    mf_q,
    output logic signed [OUT_W-1:0]    dmf_out,
    output logic signed [2*OUT_W-1:0]  ted_err
);
    import trf_pkg::*;

    trf_state_e            state_q, state_d;
    logic [TAP_W-1:0]      tap_q;
    logic [ARM_W-1:0]      arm_q;
    logic                  accept;
    logic                  run;
    logic                  last_tap;
    logic [ADDR_W-1:0]     coef_addr;
    logic signed [DATA_W-1:0] x_i, x_q;
    logic signed [COEF_W-1:0] h_coef, d_coef;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fire)     state_d = ST_RUN;
            ST_RUN:  if (last_tap) state_d = ST_DONE;
            ST_DONE:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        run  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  begin busy = 1'b1; run = 1'b1; end
            ST_DONE: begin busy = 1'b1; done = 1'b1; end
            default: ;
        endcase
    end

    assign accept   = (state_q == ST_IDLE) && fire;
    assign last_tap = (tap_q == TAP_W'(TAPS - 1));

    // ---------------- tap counter and arm latch ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= '0;
            arm_q <= '0;
        end else if (accept) begin
            tap_q <= '0;
            arm_q <= fire_arm;
        end else if (run && !last_tap) begin
            tap_q <= tap_q + 1'b1;
        end
    end

    assign coef_addr = ADDR_W'(arm_q) * ADDR_W'(TAPS) + ADDR_W'(tap_q);

    // ---------------- shared sample history ----------------
    trf_regressor #(.DEPTH(TAPS), .DATA_W(DATA_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid && (state_q == ST_IDLE)),
        .din_i    (in_i),
        .din_q    (in_q),
        .rd_idx   (tap_q),
        .rd_i     (x_i),
        .rd_q     (x_q)
    );

    // ---------------- coefficient banks ----------------
    trf_coef_rom #(.NUM_ARMS(NUM_ARMS), .TAPS(TAPS), .COEF_W(COEF_W),
                   .MUL(MF_MUL), .ADD(MF_ADD)) u_rom_mf (
        .addr (coef_addr),
        .coef (h_coef)
    );

    trf_coef_rom #(.NUM_ARMS(NUM_ARMS), .TAPS(TAPS), .COEF_W(COEF_W),
                   .MUL(DMF_MUL), .ADD(DMF_ADD)) u_rom_dmf (
        .addr (coef_addr),
        .coef (d_coef)
    );

    // ---------------- three MAC lanes: MF-I, MF-Q, DMF-I ----------------
    logic signed [DATA_W-1:0] lane_x [3];
    logic signed [COEF_W-1:0] lane_c [3];
    logic signed [OUT_W-1:0]  lane_y [3];

    assign lane_x[0] = x_i;  assign lane_c[0] = h_coef;
    assign lane_x[1] = x_q;  assign lane_c[1] = h_coef;
    assign lane_x[2] = x_i;  assign lane_c[2] = d_coef;

    for (genvar l = 0; l < 3; l++) begin : g_lane
        trf_mac_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W),
                       .ACC_W(ACC_W), .OUT_W(OUT_W)) u_mac (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (accept),
            .en     (run),
            .sample (lane_x[l]),
            .coef   (lane_c[l]),
            .result (lane_y[l])
        );
    end

    assign mf_i    = lane_y[0];
    assign mf_q    = lane_y[1];
    assign dmf_out = lane_y[2];
    assign ted_err = mf_i * dmf_out;

    // ---------------- assertions ----------------
    // R4: an idle request starts a pass on the next cycle
    p_start_on_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fire) |=> busy);

    // R4: done is a single cycle and ends the pass
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R5: the arm in use is locked for the whole pass
    p_arm_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(arm_q));

    // R6: the tap index never leaves the arm
    p_tap_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tap_q < TAP_W'(TAPS));

    // R11: results hold while idle without a request
    p_hold_results_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !fire) |=> ($stable(mf_i) && $stable(mf_q) && $stable(dmf_out)));

endmodule

// File: tb/tb_trf_pmf_engine.sv
module tb_trf_pmf_engine;

    localparam int ARMS = 32;
    localparam int TAPS = 24;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [11:0] in_i = '0;
    logic signed [11:0] in_q = '0;
    logic               fire = 1'b0;
    logic [4:0]         fire_arm = '0;
    logic               busy, done;
    logic signed [15:0] mf_i, mf_q, dmf_out;
    logic signed [31:0] ted_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int xi [TAPS];
    int xq [TAPS];

    always #5 clk = ~clk;

    trf_pmf_engine dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .fire(fire), .fire_arm(fire_arm), .busy(busy), .done(done),
        .mf_i(mf_i), .mf_q(mf_q), .dmf_out(dmf_out), .ted_err(ted_err)
    );

    // Vector table: arm index and sample pattern seed (-1 = extreme values)
    localparam int NV = 7;
    localparam int VEC_ARM  [NV] = '{0, 31, 7, 16, 1, 24, 31};
    localparam int VEC_SEED [NV] = '{3, 11, 42, 5, -1, 77, 19};

    function automatic int wrap12(int v);
        int r;
        r = v % 4096;
        if (r < 0) r = r + 4096;
        if (r >= 2048) r = r - 4096;
        return r;
    endfunction

    // R8 coefficient rules
    function automatic int h_of(int k);
        return wrap12(1237 * k + 91);
    endfunction
    function automatic int d_of(int k);
        return wrap12(2903 * k + 517);
    endfunction

    // R9 rounding
    function automatic longint rnd(longint s);
        return (s + 4096) >>> 13;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(int vi, int vq);
        @(negedge clk);
        in_valid = 1'b1;
        in_i = 12'(vi);
        in_q = 12'(vq);
        // model of R2: shift toward older positions
        for (int t = TAPS - 1; t > 0; t--) begin
            xi[t] = xi[t-1];
            xq[t] = xq[t-1];
        end
        xi[0] = vi;
        xq[0] = vq;
    endtask

    task automatic load(int seed);
        for (int n = 0; n < TAPS; n++) begin
            if (seed < 0) push(-2048, 2047 - n);
            else push(wrap12(seed * 1103 + n * 577 + 29), wrap12(seed * 389 - n * 811 + 7));
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_results(int arm, string tag);
        longint si, sq, sd, ei, eq, ed;
        si = 0; sq = 0; sd = 0;
        for (int t = 0; t < TAPS; t++) begin
            si += longint'(h_of(arm + ARMS * t)) * xi[t];
            sq += longint'(h_of(arm + ARMS * t)) * xq[t];
            sd += longint'(d_of(arm + ARMS * t)) * xi[t];
        end
        ei = rnd(si); eq = rnd(sq); ed = rnd(sd);
        check("R6", {tag, " mf_i"}, longint'(mf_i), ei);
        check("R6", {tag, " mf_q"}, longint'(mf_q), eq);
        check("R7", {tag, " dmf_out"}, longint'(dmf_out), ed);
        check("R10", {tag, " ted_err"}, longint'(ted_err), ei * ed);
    endtask

    // Fire at a falling edge, then follow the pass (R4). Optional
    // disturbance during the pass: stray fire (R5) and stray sample (R3).
    task automatic run_pass(int arm, bit disturb, string tag);
        @(negedge clk);
        fire = 1'b1;
        fire_arm = 5'(arm);
        @(negedge clk);
        fire = 1'b0;
        check("R4", {tag, " busy after fire"}, longint'(busy), 1);
        for (int c = 1; c < 24; c++) begin
            @(negedge clk);
            if (disturb && c == 5) begin
                fire = 1'b1; fire_arm = 5'((arm + 3) % ARMS);
                in_valid = 1'b1; in_i = 12'(1000); in_q = -12'sd900;
            end else begin
                fire = 1'b0; in_valid = 1'b0;
            end
            if (c == 23) check("R4", {tag, " no early done"}, longint'(done), 0);
        end
        @(negedge clk);
        check("R4", {tag, " done timing"}, longint'(done), 1);
        check("R4", {tag, " busy during done"}, longint'(busy), 1);
        expect_results(arm, tag);
        @(negedge clk);
        check("R4", {tag, " done single"}, longint'(done), 0);
        check("R5", {tag, " busy released"}, longint'(busy), 0);
    endtask

    initial begin
        for (int t = 0; t < TAPS; t++) begin xi[t] = 0; xq[t] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy", longint'(busy), 0);
        check("R1", "done", longint'(done), 0);
        check("R1", "mf_i", longint'(mf_i), 0);
        check("R1", "ted_err", longint'(ted_err), 0);
        // R1: zero history gives zero results for any arm
        run_pass(9, 1'b0, "R1 empty history");

        // Vector table walk (R2, R6..R10)
        for (int v = 0; v < NV; v++) begin
            load(VEC_SEED[v]);
            run_pass(VEC_ARM[v], 1'b0, "R2 vector");
        end

        // R3 and R5: stray fire and sample during a pass
        load(58);
        run_pass(12, 1'b1, "R5 stray fire");
        run_pass(12, 1'b0, "R3 history untouched");

        // R11: results held after done while idle
        repeat (6) @(negedge clk);
        expect_results(12, "R11 hold");

        // R2: partial shift, oldest entries dropped
        push(321, -123);
        push(-77, 555);
        @(negedge clk);
        in_valid = 1'b0;
        run_pass(30, 1'b0, "R2 partial shift");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule